// File: doc/BRIEF.md
# Cascadable Dual 8-Bit Timer

The block holds two 8-bit up-counters. Each counter has its own compare byte, a clock-select field, a clear-select field, a compare-match flag and an overflow flag. A free-running prescaler supplies three count-enable rates. Each channel picks one of these rates or stops. A small register port lets software set up the channels, load and read the counters, and clear the flags. Each channel has an external clear line. It can reset that channel's counter on a rising edge, or hold the counter at zero while the line is high.

The shared clock-select code 3'b100 chains the two channels. If channel 0 carries that code, the pair acts as one 16-bit counter. Channel 0 is the upper byte and channel 1 is the lower byte. The flags and the clearing then follow 16-bit rules. If only channel 1 carries the code, channel 1 counts the compare-match events of channel 0.

Top module: `tmr8_pair`

## Requirements
- R1: After reset every control byte and status byte reads 0x00, both counters read 0x00 and both compare bytes read 0xFF.
- R2: A clock-select value of 3'b000 freezes the counter. The values 3'b001, 3'b010 and 3'b011 advance it once per DIV1, DIV2 and DIV3 clock cycles. Clock select is control bits [2:0].
- R3: The overflow flag (status bit 1) sets when the counter steps from 0xFF to 0x00.
- R4: The compare-match flag (status bit 0) sets when the counter becomes equal to its compare byte. With clear select 2'b01 (control bits [4:3]), the step after a match loads 0x00.
- R5: Clear select 2'b10 zeroes the counter on a rising edge of that channel's external clear line. Clear select 2'b11 holds the counter at zero while the line is high.
- R6: A flag clears only when 0 is written to its bit after a status read that returned that bit as 1. Writing 1 has no effect. If a hardware set and a clear fall in the same cycle, the set wins.
- R7: When channel 0's clock select is 3'b100, channel 1 is the lower byte and steps at its own selected rate. Channel 0 is the upper byte and steps each time the lower byte wraps from 0xFF to 0x00.
- R8: In 16-bit mode, channel 0's match flag sets only when all 16 bits match. Channel 1's match flag sets on a match of the lower byte alone.
- R9: In 16-bit mode, if channel 0's clear select is 2'b01, a 16-bit match clears both bytes together. Channel 1's clear select is ignored.
- R10: When channel 1's clock select is 3'b100 and channel 0's is not, channel 1 advances once for each new compare match of channel 0.
- R11: The register address is {channel, field}, where field 0 is control, 1 is status, 2 is counter and 3 is compare. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing) |
| bus_addr | input | 3 | Register address {channel, field} |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| ext_clr | input | 2 | External clear line per channel |

## Verification
The bench builds the timer with DIV1=2, DIV2=4 and DIV3=16, in place of the large default dividers. With these values a full 8-bit wrap, and the 16-bit carry into the upper byte, take a few hundred cycles. Each rate can be checked against an expected step count in a short window. Match-count mode is driven by loading channel 0 with a counter value that equals its compare byte. This gives an exact, known number of match events, so no timing needs to be guessed.

// File: rtl/tmr8_pair.sv
module tmr8_pair #(
  parameter int DIV1 = 8,
  parameter int DIV2 = 64,
  parameter int DIV3 = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [1:0] ext_clr
);
  localparam int PW = $clog2(DIV3);
  localparam logic [PW-1:0] M1 = PW'(DIV1 - 1);
  localparam logic [PW-1:0] M2 = PW'(DIV2 - 1);
  localparam logic [PW-1:0] M3 = PW'(DIV3 - 1);

  logic [PW-1:0]   pre;
  logic [1:0][2:0] cks;
  logic [1:0][1:0] csel;
  logic [1:0][7:0] cnt, cmp;
  logic [1:0]      cmf, ovf, arm_c, arm_o, hq, xq;
  logic            h16q;

  logic t1, t2, t3, mode16, mcnt, hit16;
  logic [1:0] ist, hit, step, clr, xr, xc, cmf_ev, ovf_ev;
  logic [1:0] wctl, wst, wcnt, wcmp, rst_rd, clr_c, clr_o;

  assign t1 = (pre & M1) == M1;
  assign t2 = (pre & M2) == M2;
  assign t3 = (pre & M3) == M3;

  assign mode16 = cks[0] == 3'd4;
  assign mcnt   = (cks[1] == 3'd4) && !mode16;
  assign hit16  = hit[0] & hit[1];

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      ist[i]    = (cks[i] == 3'd1 && t1) || (cks[i] == 3'd2 && t2) || (cks[i] == 3'd3 && t3);
      hit[i]    = cnt[i] == cmp[i];
      xr[i]     = ext_clr[i] & ~xq[i];
      wctl[i]   = bus_wr && bus_addr == {i[0], 2'd0};
      wst[i]    = bus_wr && bus_addr == {i[0], 2'd1};
      wcnt[i]   = bus_wr && bus_addr == {i[0], 2'd2};
      wcmp[i]   = bus_wr && bus_addr == {i[0], 2'd3};
      rst_rd[i] = bus_rd && bus_addr == {i[0], 2'd1};
      xc[i]     = (csel[i] == 2'd2 && xr[i]) || (csel[i] == 2'd3 && ext_clr[i]);
    end
  end

  assign cmf_ev[0] = mode16 ? (hit16 & ~h16q) : (hit[0] & ~hq[0]);
  assign cmf_ev[1] = hit[1] & ~hq[1];

  assign step[1] = mcnt ? cmf_ev[0] : ist[1];
  assign clr[1]  = mode16 ? ((csel[0] == 2'd1 && hit16 && step[1]) || xc[0])
                          : ((csel[1] == 2'd1 && hit[1] && step[1]) || xc[1]);
  assign ovf_ev[1] = step[1] && cnt[1] == 8'hFF && !clr[1] && !wcnt[1];

  assign step[0] = mode16 ? ovf_ev[1] : ist[0];
  assign clr[0]  = mode16 ? clr[1] : ((csel[0] == 2'd1 && hit[0] && step[0]) || xc[0]);
  assign ovf_ev[0] = step[0] && cnt[0] == 8'hFF && !clr[0] && !wcnt[0];

  assign clr_c = wst & ~{2{bus_wdata[0]}} & arm_c;
  assign clr_o = wst & ~{2{bus_wdata[1]}} & arm_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre  <= '0;
      cks  <= '0;
      csel <= '0;
      cnt  <= '0;
      cmp  <= {8'hFF, 8'hFF};
      cmf  <= '0;
      ovf  <= '0;
      arm_c <= '0;
      arm_o <= '0;
      hq   <= '0;
      xq   <= '0;
      h16q <= 1'b0;
    end else begin
      pre  <= pre + 1'b1;
      hq   <= hit;
      xq   <= ext_clr;
      h16q <= hit16;
      for (int i = 0; i < 2; i++) begin
        if (wctl[i]) begin
          cks[i]  <= bus_wdata[2:0];
          csel[i] <= bus_wdata[4:3];
        end
        if (wcmp[i]) cmp[i] <= bus_wdata;
        if (wcnt[i])      cnt[i] <= bus_wdata;
        else if (clr[i])  cnt[i] <= 8'h00;
        else if (step[i]) cnt[i] <= cnt[i] + 8'd1;
        cmf[i] <= cmf_ev[i] | (cmf[i] & ~clr_c[i]);
        ovf[i] <= ovf_ev[i] | (ovf[i] & ~clr_o[i]);
        if (clr_c[i])                   arm_c[i] <= 1'b0;
        else if (rst_rd[i] && cmf[i])   arm_c[i] <= 1'b1;
        if (clr_o[i])                   arm_o[i] <= 1'b0;
        else if (rst_rd[i] && ovf[i])   arm_o[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr[1:0])
      2'd0:    bus_rdata = {3'b000, csel[bus_addr[2]], cks[bus_addr[2]]};
      2'd1:    bus_rdata = {6'b0, ovf[bus_addr[2]], cmf[bus_addr[2]]};
      2'd2:    bus_rdata = cnt[bus_addr[2]];
      default: bus_rdata = cmp[bus_addr[2]];
    endcase
  end
endmodule

// File: rtl/tmr8_pair_chk.sv
module tmr8_pair_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            mode16,
  input logic            mcnt,
  input logic [1:0][2:0] cks,
  input logic [1:0][7:0] cnt,
  input logic [1:0]      cmf,
  input logic [1:0]      ovf,
  input logic [1:0]      cmf_ev,
  input logic [1:0]      ovf_ev,
  input logic [1:0]      clr,
  input logic [1:0]      wcnt
);
  a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cks[0] == 3'd0 && !wcnt[0] && !clr[0]) |=> cnt[0] == $past(cnt[0]));

  a_r3_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev[0] |=> ovf[0]);

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmf_ev[1] |=> cmf[1]);

  a_r7_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode16 && ovf_ev[1] && !clr[0] && !wcnt[0]) |=> cnt[0] == $past(cnt[0]) + 8'd1);

  a_r9_clear_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (mode16 && clr[0] && !wcnt[0] && !wcnt[1]) |=> (cnt[0] == 8'h00 && cnt[1] == 8'h00));

  a_r10_event_count: assert property (@(posedge clk) disable iff (!rst_n)
    (mcnt && cmf_ev[0] && !clr[1] && !wcnt[1]) |=> cnt[1] == $past(cnt[1]) + 8'd1);
endmodule

bind tmr8_pair tmr8_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode16(mode16), .mcnt(mcnt), .cks(cks), .cnt(cnt),
  .cmf(cmf), .ovf(ovf), .cmf_ev(cmf_ev), .ovf_ev(ovf_ev), .clr(clr), .wcnt(wcnt)
);

// File: tb/tmr8_pair_bench.sv
module tmr8_pair_bench;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [1:0] ext_clr = 0;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  tmr8_pair #(.DIV1(2), .DIV2(4), .DIV3(16)) u_tmr8_pair (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clr(ext_clr));

  localparam logic [2:0] C0 = 3'd0, S0 = 3'd1, N0 = 3'd2, K0 = 3'd3;
  localparam logic [2:0] C1 = 3'd4, S1 = 3'd5, N1 = 3'd6, K1 = 3'd7;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_true(string req, logic ok, logic [7:0] act, string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%s", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; ext_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic poll(logic [2:0] a, logic [7:0] v, int lim, output logic ok);
    logic [7:0] d;
    ok = 0;
    for (int k = 0; k < lim && !ok; k++) begin
      rd(a, d);
      if (d == v) ok = 1;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1/R11 reset value", d, (a % 4 == 3) ? 8'hFF : 8'h00);
    end
  endtask

  task automatic t_rates();
    logic [7:0] d;
    do_reset();
    wr(N0, 8'h10);
    repeat (20) @(negedge clk);
    rd(N0, d); check("R2 select 000 holds", d, 8'h10);
    wr(N0, 8'h00); wr(C0, 8'h01);
    repeat (40) @(negedge clk);
    wr(C0, 8'h00); rd(N0, d);
    check_true("R2 divide-by-2 rate", d >= 8'd19 && d <= 8'd22, d, "19..22");
    wr(N0, 8'h00); wr(C0, 8'h02);
    repeat (64) @(negedge clk);
    wr(C0, 8'h00); rd(N0, d);
    check_true("R2 divide-by-4 rate", d >= 8'd15 && d <= 8'd17, d, "15..17");
    wr(N0, 8'h00); wr(C0, 8'h03);
    repeat (64) @(negedge clk);
    wr(C0, 8'h00); rd(N0, d);
    check_true("R2 divide-by-16 rate", d >= 8'd3 && d <= 8'd5, d, "3..5");
  endtask

  task automatic t_overflow();
    logic [7:0] d; logic ok;
    do_reset();
    wr(K0, 8'h80); wr(N0, 8'hFE); wr(C0, 8'h01);
    poll(N0, 8'h00, 40, ok);
    check("R3 counter wraps", {7'b0, ok}, 8'h01);
    rd(S0, d); check("R3 overflow flag only", d, 8'h02);
  endtask

  task automatic t_match();
    logic [7:0] d; logic ok;
    do_reset();
    wr(K0, 8'h05); wr(C0, 8'h09);
    poll(N0, 8'h05, 40, ok);
    check("R4 reaches compare", {7'b0, ok}, 8'h01);
    d = 8'h05;
    for (int k = 0; k < 10 && d == 8'h05; k++) rd(N0, d);
    check("R4 clear on match", d, 8'h00);
    rd(S0, d); check("R4 match flag", d, 8'h01);
  endtask

  task automatic t_ext();
    logic [7:0] d;
    do_reset();
    wr(C1, 8'h10); wr(N1, 8'h40);
    @(negedge clk); ext_clr[1] = 1;
    rd(N1, d); check("R5 rising-edge clear", d, 8'h00);
    wr(N1, 8'h22); rd(N1, d); check("R5 edge mode ignores held level", d, 8'h22);
    @(negedge clk); ext_clr[1] = 0;
    wr(C1, 8'h19);
    @(negedge clk); ext_clr[1] = 1;
    repeat (10) @(negedge clk);
    rd(N1, d); check("R5 level clear holds zero", d, 8'h00);
    repeat (10) @(negedge clk);
    rd(N1, d); check("R5 level clear still zero", d, 8'h00);
    ext_clr[1] = 0;
    repeat (10) @(negedge clk);
    rd(N1, d); check_true("R5 counts after release", d != 8'h00, d, "nonzero");
  endtask

  task automatic t_flags();
    logic [7:0] d;
    do_reset();
    wr(K0, 8'h33); wr(N0, 8'h33);
    wr(S0, 8'h00); rd(S0, d); check("R6 write without read keeps flag", d, 8'h01);
    wr(S0, 8'h03); rd(S0, d); check("R6 writing one keeps flag", d, 8'h01);
    wr(S0, 8'h00); rd(S0, d); check("R6 read then write zero clears", d, 8'h00);
  endtask

  task automatic t_c16();
    logic [7:0] d; logic ok;
    do_reset();
    wr(C0, 8'h04); wr(K0, 8'h80); wr(K1, 8'h80);
    wr(N1, 8'hFE); wr(C1, 8'h01);
    poll(N1, 8'h00, 40, ok);
    wr(C1, 8'h00);
    rd(N0, d); check("R7 upper byte carries", d, 8'h01);
    rd(S1, d); check("R7 lower byte overflow flag", d[1], 1'b1);
    rd(S0, d); check("R7 upper byte no overflow", d[1], 1'b0);
  endtask

  task automatic t_c16match();
    logic [7:0] d; logic ok;
    do_reset();
    wr(C0, 8'h04); wr(K1, 8'h03); wr(K0, 8'h01); wr(C1, 8'h01);
    poll(N1, 8'h03, 40, ok);
    rd(S1, d); check("R8 lower-byte match flag", d[0], 1'b1);
    rd(S0, d); check("R8 no 16-bit match yet", d[0], 1'b0);
    poll(S0, 8'h01, 2000, ok);
    check("R8 16-bit match flag", {7'b0, ok}, 8'h01);
  endtask

  task automatic t_c16clr();
    logic [7:0] d; logic ok;
    do_reset();
    wr(C0, 8'h0C); wr(K1, 8'h02); wr(K0, 8'h01); wr(C1, 8'h09);
    poll(N1, 8'h04, 40, ok);
    check("R9 channel 1 clear select ignored", {7'b0, ok}, 8'h01);
    poll(S0, 8'h01, 2000, ok);
    wr(C1, 8'h08);
    rd(N0, d); check("R9 upper byte cleared", d, 8'h00);
    rd(N1, d); check_true("R9 lower byte cleared", d < 8'h08, d, "<08");
  endtask

  task automatic t_mcnt();
    logic [7:0] d;
    do_reset();
    wr(C1, 8'h04); wr(K0, 8'h07);
    wr(N0, 8'h07); wr(N0, 8'h00); wr(N0, 8'h07); wr(N0, 8'h07);
    rd(N1, d); check("R10 one step per channel 0 match", d, 8'h02);
  endtask

  initial begin
    #(20ns * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_rates();
    t_overflow();
    t_match();
    t_ext();
    t_flags();
    t_c16();
    t_c16match();
    t_c16clr();
    t_mcnt();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule